// File: doc/BRIEF.md
# I/O Window Address Decoder

This block sits between a processor's 16-bit I/O window and the devices behind it. Each access carries an 11-bit word offset and two byte-lane enables. The decoder splits the offset into a region, a sub-select and an index. It raises exactly one device select and hands the device its local index. On reads it steers the selected device's byte onto the low half of the response.

Four expansion slots are reachable. Each has a small register space and a larger ROM space. A single slot-status location sits beside them. A clock/calendar window is opened and closed through an on-board strobe register, which also latches the calendar's nibble address. Eight on-board peripheral strobes sit in the top region. Only accesses that use the low byte lane do anything. Peripherals are modelled as external read ports and selects, and the read response returns one cycle after the request.

Top module: `iomap_decoder`

## Requirements
- R1: An access with `req_be[0]`=0 selects no device, pulses no write, and leaves the calendar latch unchanged. If it is a read, it responds with 0x0000. An access with `req_be[0]`=1 takes effect whatever `req_be[1]` holds.
- R2: Offset bits [10:8] pick the region: 0 slot registers, 1 to 4 ROM of slots 1 to 4, 5 slot status (`stat_sel`), 6 calendar, 7 on-board ports.
- R3: In region 0, offset bits [6:4] equal to k (1 to 4) select the register space of slot k (`slot_reg_sel` bit k-1). In this case `slot_idx` is offset bits [3:0], zero-extended. Any other value of bits [6:4] selects nothing and reads 0.
- R4: In ROM region k, `slot_rom_sel` bit k-1 is raised and `slot_idx` equals offset bits [7:0].
- R5: In region 7, offset bits [6:4] raise `dev_sel` bit d with `dev_idx` = offset bits [3:0]. The device codes are: 0 keyboard, 1 serial 0, 2 serial 1, 3 interface adapter, 4 calendar strobe, 5 network strobe, 6 network interrupt clear, 7 external ROM strobe. A read returns that device's byte of `dev_rdata` (byte d at bits [8d+7:8d]).
- R6: A write to device 4 changes the calendar enable only when data bit 4 differs from the current enable. When the write drives the enable to 0, data bits [3:0] become `cal_addr` from the next cycle on. No other write changes `cal_addr`.
- R7: A region-6 access reaches the calendar (`cal_sel`) only while the enable is 0. A read then returns `cal_rdata` zero-extended. While the enable is 1, a region-6 access selects nothing and reads 0. `cal_wdata` carries write data bits [3:0].
- R8: A read of serial 0 or serial 1 at index 1 returns 0x10, whatever the device port holds.
- R9: A slot whose `slot_present` bit is 0 is never selected. Reads of it return 0 and writes to it raise no select.
- R10: After reset the calendar enable is 0 and `cal_addr` is 0.
- R11: A read request is answered in the next cycle by `rsp_valid`=1, with the byte in `rsp_rdata[7:0]` and `rsp_rdata[15:8]`=0. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_be | input | 2 | Byte-lane enables, bit 0 low lane |
| req_addr | input | 11 | Word offset inside the I/O window |
| req_wdata | input | 8 | Low-lane write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 16 | Read response data |
| slot_present | input | 4 | Device fitted in each slot |
| slot_reg_sel | output | 4 | Slot register-space selects |
| slot_rom_sel | output | 4 | Slot ROM-space selects |
| slot_idx | output | 8 | Index inside the selected slot space |
| slot_reg_rdata | input | 32 | Register read bytes, slot k at byte k-1 |
| slot_rom_rdata | input | 32 | ROM read bytes, slot k at byte k-1 |
| stat_sel | output | 1 | Slot-status select |
| stat_rdata | input | 8 | Slot-status read byte |
| cal_sel | output | 1 | Calendar select |
| cal_addr | output | 4 | Latched calendar address |
| cal_wdata | output | 4 | Calendar write nibble |
| cal_rdata | input | 4 | Calendar read nibble |
| dev_sel | output | 8 | On-board device strobes |
| dev_idx | output | 4 | On-board register index |
| dev_rdata | input | 64 | On-board read bytes, device d at byte d |
| wr_en | output | 1 | Write strobe, qualified by the selects |
| wr_byte | output | 8 | Write data to all devices |

## Verification
The bench builds the block with its default values: four slots and 8-bit lanes. That puts every region code and every sub-select value of the 3-bit fields within reach, including the out-of-range slot codes 0 and 5 to 7. Slot 4 is tied absent, so the presence gating is exercised in both its register and ROM spaces, next to fitted slots. Each slot and device drives a distinct byte, so a wrong steering in the read path shows up in the response.

// File: rtl/iomap_pkg.sv
package iomap_pkg;
  localparam int RGN_LSB   = 8;
  localparam int FIELD_W   = 3;
  localparam int SUB_LSB   = 4;
  localparam int IDX_W     = 4;
  localparam int ROMIX_W   = 8;
  localparam int OFS_W     = RGN_LSB + FIELD_W;
  localparam int NDEV      = 1 << FIELD_W;
  localparam int CAL_W     = 4;
  localparam int CAL_EN_BIT = 4;

  typedef enum logic [FIELD_W-1:0] {
    RG_SLOTREG = 3'd0,
    RG_ROM1    = 3'd1,
    RG_ROM2    = 3'd2,
    RG_ROM3    = 3'd3,
    RG_ROM4    = 3'd4,
    RG_STATUS  = 3'd5,
    RG_CAL     = 3'd6,
    RG_PORTS   = 3'd7
  } region_e;

  localparam logic [FIELD_W-1:0] DEV_SER0   = 3'd1;
  localparam logic [FIELD_W-1:0] DEV_SER1   = 3'd2;
  localparam logic [FIELD_W-1:0] DEV_CALSTB = 3'd4;
  localparam logic [IDX_W-1:0]   SER_STAT_IDX = 4'd1;
  localparam logic [7:0]         SER_STAT_VAL = 8'h10;
endpackage

// File: rtl/iomap_addr_dec.sv
module iomap_addr_dec
  import iomap_pkg::*;
#(
  parameter int NSLOT = 4
) (
  input  logic                 acc,
  input  logic [OFS_W-1:0]     addr,
  input  logic [NSLOT-1:0]     present,
  input  logic                 cal_open,
  output logic [NSLOT-1:0]     reg_sel,
  output logic [NSLOT-1:0]     rom_sel,
  output logic [ROMIX_W-1:0]   sidx,
  output logic                 stat_sel,
  output logic                 cal_sel,
  output logic [NDEV-1:0]      dev_sel,
  output logic [IDX_W-1:0]     didx
);
  region_e              region;
  logic [FIELD_W-1:0]   sub;
  logic [IDX_W-1:0]     lidx;

  assign region = region_e'(addr[RGN_LSB +: FIELD_W]);
  assign sub    = addr[SUB_LSB +: FIELD_W];
  assign lidx   = addr[IDX_W-1:0];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [FIELD_W-1:0] CODE = FIELD_W'(g + 1);
    assign reg_sel[g] = acc && present[g] && (region == RG_SLOTREG) && (sub == CODE);
    assign rom_sel[g] = acc && present[g] && (addr[RGN_LSB +: FIELD_W] == CODE);
  end

  always_comb begin
    if (region == RG_SLOTREG) sidx = {{(ROMIX_W-IDX_W){1'b0}}, lidx};
    else                      sidx = addr[ROMIX_W-1:0];
  end

  assign stat_sel = acc && (region == RG_STATUS);
  assign cal_sel  = acc && cal_open && (region == RG_CAL);

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    assign dev_sel[d] = acc && (region == RG_PORTS) && (sub == FIELD_W'(d));
  end

  assign didx = lidx;
endmodule

// File: rtl/iomap_cal_latch.sv
module iomap_cal_latch
  import iomap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_wr,
  input  logic [7:0]       wdata,
  output logic             en,
  output logic [CAL_W-1:0] addr
);
  logic             en_q, en_d;
  logic [CAL_W-1:0] addr_q, addr_d;
  logic             upd;

  assign upd = stb_wr && (wdata[CAL_EN_BIT] != en_q);

  always_comb begin
    en_d   = wdata[CAL_EN_BIT];
    addr_d = addr_q;
    if (!wdata[CAL_EN_BIT]) addr_d = wdata[CAL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else if (upd) begin
      en_q   <= en_d;
      addr_q <= addr_d;
    end
  end

  assign en   = en_q;
  assign addr = addr_q;
endmodule

// File: rtl/iomap_rd_mux.sv
module iomap_rd_mux
  import iomap_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [NSLOT-1:0]        reg_sel,
  input  logic [NSLOT-1:0]        rom_sel,
  input  logic                    stat_sel,
  input  logic                    cal_sel,
  input  logic [NDEV-1:0]         dev_sel,
  input  logic [IDX_W-1:0]        didx,
  input  logic [NSLOT*BYTE_W-1:0] reg_rdata,
  input  logic [NSLOT*BYTE_W-1:0] rom_rdata,
  input  logic [BYTE_W-1:0]       stat_rdata,
  input  logic [CAL_W-1:0]        cal_rdata,
  input  logic [NDEV*BYTE_W-1:0]  dev_rdata,
  output logic [BYTE_W-1:0]       rd
);
  logic ser_stat;

  assign ser_stat = (dev_sel[DEV_SER0] || dev_sel[DEV_SER1]) && (didx == SER_STAT_IDX);

  always_comb begin
    rd = '0;
    for (int g = 0; g < NSLOT; g++) begin
      if (reg_sel[g]) rd = rd | reg_rdata[g*BYTE_W +: BYTE_W];
      if (rom_sel[g]) rd = rd | rom_rdata[g*BYTE_W +: BYTE_W];
    end
    if (stat_sel) rd = rd | stat_rdata;
    if (cal_sel)  rd = rd | {{(BYTE_W-CAL_W){1'b0}}, cal_rdata};
    for (int d = 0; d < NDEV; d++) begin
      if (dev_sel[d]) rd = rd | dev_rdata[d*BYTE_W +: BYTE_W];
    end
    if (ser_stat) rd = BYTE_W'(SER_STAT_VAL);
  end
endmodule

// File: rtl/iomap_decoder.sv
module iomap_decoder
  import iomap_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [1:0]              req_be,
  input  logic [OFS_W-1:0]        req_addr,
  input  logic [BYTE_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [2*BYTE_W-1:0]     rsp_rdata,
  input  logic [NSLOT-1:0]        slot_present,
  output logic [NSLOT-1:0]        slot_reg_sel,
  output logic [NSLOT-1:0]        slot_rom_sel,
  output logic [ROMIX_W-1:0]      slot_idx,
  input  logic [NSLOT*BYTE_W-1:0] slot_reg_rdata,
  input  logic [NSLOT*BYTE_W-1:0] slot_rom_rdata,
  output logic                    stat_sel,
  input  logic [BYTE_W-1:0]       stat_rdata,
  output logic                    cal_sel,
  output logic [CAL_W-1:0]        cal_addr,
  output logic [CAL_W-1:0]        cal_wdata,
  input  logic [CAL_W-1:0]        cal_rdata,
  output logic [NDEV-1:0]         dev_sel,
  output logic [IDX_W-1:0]        dev_idx,
  input  logic [NDEV*BYTE_W-1:0]  dev_rdata,
  output logic                    wr_en,
  output logic [BYTE_W-1:0]       wr_byte
);
  localparam int RSP_W = 2 * BYTE_W;

  logic       rst_meta_q, rst_sync_n;
  logic       acc;
  logic       cal_en;
  logic       stb_wr;
  logic [BYTE_W-1:0] rd_byte;
  logic              rsp_valid_q, rsp_valid_d;
  logic [RSP_W-1:0]  rsp_data_q, rsp_data_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign acc = req_valid && req_be[0];

  iomap_addr_dec #(.NSLOT(NSLOT)) u_dec (
    .acc      (acc),
    .addr     (req_addr),
    .present  (slot_present),
    .cal_open (!cal_en),
    .reg_sel  (slot_reg_sel),
    .rom_sel  (slot_rom_sel),
    .sidx     (slot_idx),
    .stat_sel (stat_sel),
    .cal_sel  (cal_sel),
    .dev_sel  (dev_sel),
    .didx     (dev_idx)
  );

  assign stb_wr = req_write && dev_sel[DEV_CALSTB];

  iomap_cal_latch u_cal (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .stb_wr (stb_wr),
    .wdata  (req_wdata),
    .en     (cal_en),
    .addr   (cal_addr)
  );

  iomap_rd_mux #(.NSLOT(NSLOT), .BYTE_W(BYTE_W)) u_mux (
    .reg_sel    (slot_reg_sel),
    .rom_sel    (slot_rom_sel),
    .stat_sel   (stat_sel),
    .cal_sel    (cal_sel),
    .dev_sel    (dev_sel),
    .didx       (dev_idx),
    .reg_rdata  (slot_reg_rdata),
    .rom_rdata  (slot_rom_rdata),
    .stat_rdata (stat_rdata),
    .cal_rdata  (cal_rdata),
    .dev_rdata  (dev_rdata),
    .rd         (rd_byte)
  );

  assign wr_en     = acc && req_write;
  assign wr_byte   = req_wdata;
  assign cal_wdata = req_wdata[CAL_W-1:0];

  always_comb begin
    rsp_valid_d = req_valid && !req_write;
    rsp_data_d  = '0;
    if (acc && !req_write) rsp_data_d = {{BYTE_W{1'b0}}, rd_byte};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
endmodule

// File: rtl/iomap_decoder_chk.sv
module iomap_decoder_chk
  import iomap_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [1:0]          req_be,
  input logic [OFS_W-1:0]    req_addr,
  input logic                rsp_valid,
  input logic [2*BYTE_W-1:0] rsp_rdata,
  input logic [NSLOT-1:0]    slot_present,
  input logic [NSLOT-1:0]    slot_reg_sel,
  input logic [NSLOT-1:0]    slot_rom_sel,
  input logic                stat_sel,
  input logic                cal_sel,
  input logic                cal_en,
  input logic [CAL_W-1:0]    cal_addr,
  input logic [NDEV-1:0]     dev_sel,
  input logic                wr_en
);
  logic any_sel;
  logic stb_write;
  assign any_sel = (|slot_reg_sel) || (|slot_rom_sel) || stat_sel || cal_sel || (|dev_sel);
  assign stb_write = req_valid && req_write && req_be[0]
                   && (req_addr[RGN_LSB +: FIELD_W] == 3'd7)
                   && (req_addr[SUB_LSB +: FIELD_W] == DEV_CALSTB);

  AST_LOWLANE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!req_valid || !req_be[0]) |-> (!any_sel && !wr_en)); // R1

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({slot_reg_sel, slot_rom_sel, stat_sel, cal_sel, dev_sel})); // R2

  AST_CAL_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cal_sel |-> !cal_en); // R7

  AST_CAL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !stb_write |=> $stable(cal_addr)); // R6

  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((slot_reg_sel | slot_rom_sel) & ~slot_present) == '0); // R9

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_write) |=> rsp_valid); // R11

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R11

  AST_RSP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> (rsp_rdata[2*BYTE_W-1:BYTE_W] == '0)); // R11
endmodule

bind iomap_decoder iomap_decoder_chk #(.NSLOT(NSLOT), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/iomap_decoder_tb.sv
module iomap_decoder_tb;
  localparam int NSLOT = 4;
  localparam int BW    = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [1:0]        req_be = 2'b00;
  logic [10:0]       req_addr = '0;
  logic [7:0]        req_wdata = '0;
  logic              rsp_valid;
  logic [15:0]       rsp_rdata;
  logic [3:0]        slot_present = 4'b0111;
  logic [3:0]        slot_reg_sel, slot_rom_sel;
  logic [7:0]        slot_idx;
  logic [31:0]       slot_reg_rdata = 32'hA3A2A1A0;
  logic [31:0]       slot_rom_rdata = 32'hB3B2B1B0;
  logic              stat_sel;
  logic [7:0]        stat_rdata = 8'h5A;
  logic              cal_sel;
  logic [3:0]        cal_addr, cal_wdata;
  logic [3:0]        cal_rdata = 4'h9;
  logic [7:0]        dev_sel;
  logic [3:0]        dev_idx;
  logic [63:0]       dev_rdata = 64'hC7C6C5C4C3C2C1C0;
  logic              wr_en;
  logic [7:0]        wr_byte;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  iomap_decoder #(.NSLOT(NSLOT), .BYTE_W(BW)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] ofs(input int rg, input int sub, input int idx);
    return {rg[2:0], 1'b0, sub[2:0], idx[3:0]};
  endfunction

  // drive one access at a falling edge; a read queues its expected response
  task automatic access(input logic wr, input logic [1:0] be, input logic [10:0] a,
                        input logic [7:0] wd, input logic [7:0] exp_rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_be = be; req_addr = a; req_wdata = wd;
    if (!wr) exp_q.push_back({8'h00, exp_rd});
    #4;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = 2'b00;
    #4;
  endtask

  // monitor: compare each response with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R11 unexpected response", 1, 0);
      else chk("R11 response data", rsp_rdata, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 20);
    chk("watchdog expired", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10 cal_addr after reset", cal_addr, 0);
    access(1'b0, 2'b01, ofs(6, 0, 3), 8'h00, 8'h09);
    chk("R10 calendar open after reset", cal_sel, 1);

    // R3 slot register read
    access(1'b0, 2'b01, ofs(0, 2, 11), 8'h00, 8'hA1);
    chk("R3 reg select slot2", slot_reg_sel, 4'b0010);
    chk("R3 reg index", slot_idx, 8'h0B);
    access(1'b0, 2'b01, ofs(0, 0, 2), 8'h00, 8'h00);
    chk("R3 sub 0 selects nothing", {slot_reg_sel, slot_rom_sel, dev_sel, stat_sel, cal_sel}, 0);
    access(1'b0, 2'b01, ofs(0, 5, 2), 8'h00, 8'h00);
    chk("R3 sub 5 selects nothing", {slot_reg_sel, slot_rom_sel, dev_sel, stat_sel, cal_sel}, 0);
    access(1'b1, 2'b01, ofs(0, 1, 3), 8'h77, 8'h00);
    chk("R3 write slot1 select", slot_reg_sel, 4'b0001);
    chk("R3 write strobe and data", {wr_en, wr_byte}, {1'b1, 8'h77});

    // R4 ROM
    access(1'b0, 2'b01, {3'd3, 8'hC5}, 8'h00, 8'hB2);
    chk("R4 rom select slot3", slot_rom_sel, 4'b0100);
    chk("R4 rom index", slot_idx, 8'hC5);

    // R9 absent slot 4
    access(1'b0, 2'b01, {3'd4, 8'h10}, 8'h00, 8'h00);
    chk("R9 absent rom not selected", slot_rom_sel, 0);
    access(1'b1, 2'b01, ofs(0, 4, 1), 8'h33, 8'h00);
    chk("R9 absent reg write not selected", slot_reg_sel, 0);

    // R2 status region
    access(1'b0, 2'b01, ofs(5, 0, 0), 8'h00, 8'h5A);
    chk("R2 status select", stat_sel, 1);

    // R5 on-board devices
    access(1'b0, 2'b01, ofs(7, 3, 6), 8'h00, 8'hC3);
    chk("R5 adapter strobe", dev_sel, 8'h08);
    chk("R5 device index", dev_idx, 4'h6);
    access(1'b0, 2'b01, ofs(7, 7, 0), 8'h00, 8'hC7);
    chk("R5 external rom strobe", dev_sel, 8'h80);
    access(1'b0, 2'b01, ofs(7, 0, 1), 8'h00, 8'hC0); // R5 keyboard, no override
    access(1'b0, 2'b01, ofs(7, 1, 0), 8'h00, 8'hC1); // R5 serial 0 index 0

    // R8 serial status
    access(1'b0, 2'b01, ofs(7, 1, 1), 8'h00, 8'h10);
    access(1'b0, 2'b01, ofs(7, 2, 1), 8'h00, 8'h10);
    chk("R8 serial1 strobe", dev_sel, 8'h04);

    // R1 lane qualification
    access(1'b0, 2'b10, ofs(0, 2, 0), 8'h00, 8'h00);
    chk("R1 high lane no select", {slot_reg_sel, wr_en}, 0);
    access(1'b0, 2'b00, ofs(5, 0, 0), 8'h00, 8'h00);
    chk("R1 no lane no select", stat_sel, 0);
    access(1'b0, 2'b11, ofs(0, 2, 0), 8'h00, 8'hA1);
    chk("R1 both lanes take effect", slot_reg_sel, 4'b0010);

    // R6 / R7 calendar latch
    access(1'b1, 2'b01, ofs(7, 4, 0), 8'h13, 8'h00);
    idle();
    chk("R6 rising enable keeps address", cal_addr, 0);
    access(1'b0, 2'b01, ofs(6, 0, 0), 8'h00, 8'h00);
    chk("R7 calendar closed while enabled", cal_sel, 0);
    access(1'b1, 2'b10, ofs(7, 4, 0), 8'h0C, 8'h00);
    idle();
    chk("R1 high-lane strobe write ignored", cal_addr, 0);
    access(1'b0, 2'b01, ofs(6, 0, 0), 8'h00, 8'h00);
    chk("R1 calendar still closed", cal_sel, 0);
    access(1'b1, 2'b01, ofs(7, 4, 0), 8'h05, 8'h00);
    idle();
    chk("R6 falling enable latches address", cal_addr, 4'h5);
    access(1'b1, 2'b01, ofs(7, 4, 0), 8'h0A, 8'h00);
    idle();
    chk("R6 same enable leaves address", cal_addr, 4'h5);
    access(1'b1, 2'b01, ofs(6, 0, 0), 8'hFE, 8'h00);
    chk("R7 calendar write reaches", {cal_sel, wr_en, cal_wdata}, {1'b1, 1'b1, 4'hE});
    access(1'b0, 2'b01, ofs(6, 0, 0), 8'h00, 8'h09);
    chk("R7 calendar read select", cal_sel, 1);

    idle();
    repeat (3) @(negedge clk);
    chk("R11 all responses seen", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule